// File: doc/BRIEF.md
# Scatter-Gather Audio DMA Channel

This block is one playback DMA channel for an audio controller. Software builds a table of 64-bit descriptors in memory. Each descriptor holds a buffer pointer word and a word with a byte count and three marker bits. Software loads the table base, then writes the start bit. The channel then walks the table one descriptor at a time. It fetches each data byte through a simple read port and sends it out on a valid/ready byte stream.

Three marker bits control what happens when a segment finishes. The flag bit raises a status event. The end-of-list bit raises a different status event and either ends the run or, with looping enabled, sends the channel back to the first descriptor. The halt bit stops the channel after that segment. Either status event can drive the interrupt line through its own enable, and the line stays high until software clears the event.

Software can read the segment index and the bytes still left in that segment at any time, and compute the live play position from them. A stop write halts the channel at once, whatever it is doing.

Top module: `sgdma_chan`

## Requirements
- R1: Descriptor i sits at table_base + 8*i. The pointer word is at offset 0 and the flags/count word at offset 4. In the flags word, bit 31 is end-of-list, bit 30 is flag, bit 29 is halt, and bits 23:0 are the byte count.
- R2: A segment's bytes go out in ascending address order from its pointer, one byte per handshake. The byte at address a is lane a[1:0] (little-endian) of the 32-bit word read at {a[31:2],2'b00}. While out_ready is low, out_data and out_valid hold.
- R3: The registers use word offsets on reg_addr: 0 table base, 1 control, 2 status, 3 position. Control bits are 0 start, 1 stop, 2 loop, 3 end-of-list interrupt enable and 4 flag interrupt enable. Status bits are 0 end-of-list, 1 flag, 2 interrupt pending and 3 active. Status bits 0 and 1 clear when 1 is written to them.
- R4: The position register returns the current segment index in bits 31:24 and the bytes remaining in that segment in bits 23:0.
- R5: When a descriptor with the flag bit set completes, status flag is set. If the flag enable is set, irq is asserted and stays high until the flag is cleared.
- R6: When the end-of-list descriptor completes, status end-of-list is set and irq follows its enable. Without loop, the channel goes idle and keeps the index of that last segment.
- R7: With loop set, the channel restarts at descriptor 0 after the end-of-list descriptor and stays active.
- R8: A descriptor with the halt bit set stops the channel after its segment.
- R9: A descriptor with a zero byte count completes at once and sends no bytes.
- R10: Writing stop halts the channel at once, and no further bytes go out. Writing control 0 and then clearing both status events returns every status bit to 0.
- R11: After reset the channel is idle, all registers read 0, irq is low, and it makes no memory request and presents no stream data.
- R12: With an enable clear, the matching status event is still recorded but irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, held until mem_rvalid |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_rvalid | input | 1 | Read data valid, one cycle per request |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_ready | input | 1 | Stream sink ready |
| irq | output | 1 | Interrupt request (level) |

## Verification
The main walk is run with several tables and sink patterns:

- A flag segment followed by an end-of-list segment that starts at an odd address. This separates lane selection from pointer increment and checks both status events together.
- The same table with the enables cleared. This shows that recording an event is separate from raising the interrupt.
- A table with a zero-count segment, then a halting segment, then an unreached end-of-list segment. This shows that an empty segment sends nothing and that the halt bit wins over walking on.
- A looping one-segment table that crosses a word boundary. This exercises the wrap to index 0 and the stop write.
- A fully stalled sink. This freezes the channel on its first byte, so the held byte and the untouched remaining count can be read back.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;
  localparam int CNT_W  = 24;
  localparam int BYTE_W = 8;

  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_POS  = 2'd3;

  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_LOOP  = 2;
  localparam int CB_IEEOL = 3;
  localparam int CB_IEFLG = 4;

  localparam int DB_EOL  = 31;
  localparam int DB_FLAG = 30;
  localparam int DB_HALT = 29;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC_A, ST_DESC_F, ST_BYTE_RD, ST_BYTE_OUT
  } eng_state_t;

  function automatic logic [ADDR_W-1:0] desc_word_addr(
      input logic [ADDR_W-1:0] base, input logic [IDX_W-1:0] idx, input logic hi);
    logic [ADDR_W-1:0] off;
    off = ADDR_W'(idx) << 3;
    return base + off + (hi ? ADDR_W'(4) : ADDR_W'(0));
  endfunction

  function automatic logic [BYTE_W-1:0] lane_byte(
      input logic [DATA_W-1:0] word, input logic [1:0] lane);
    return word[lane*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              seg_eol,
  input  logic              seg_flag,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [CNT_W-1:0]  cur_remain,
  input  logic              active,
  output logic [ADDR_W-1:0] table_base,
  output logic              loop_en,
  output logic              ie_eol,
  output logic              ie_flag,
  output logic              start_go,
  output logic              halt_req,
  output logic              irq
);
  logic st_eol, st_flag;
  logic wr_ctrl, wr_stat;

  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign wr_stat  = reg_we && (reg_addr == RA_STAT);
  assign start_go = wr_ctrl && reg_wdata[CB_START] && !reg_wdata[CB_STOP] && !active;
  assign halt_req = wr_ctrl && reg_wdata[CB_STOP];
  assign irq      = (st_eol && ie_eol) || (st_flag && ie_flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      table_base <= '0;
      loop_en    <= 1'b0;
      ie_eol     <= 1'b0;
      ie_flag    <= 1'b0;
      st_eol     <= 1'b0;
      st_flag    <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_BASE) table_base <= reg_wdata;
      if (wr_ctrl) begin
        loop_en <= reg_wdata[CB_LOOP];
        ie_eol  <= reg_wdata[CB_IEEOL];
        ie_flag <= reg_wdata[CB_IEFLG];
      end
      st_eol  <= (st_eol  && !(wr_stat && reg_wdata[0])) || seg_eol;
      st_flag <= (st_flag && !(wr_stat && reg_wdata[1])) || seg_flag;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_BASE: reg_rdata = table_base;
      RA_CTRL: reg_rdata = DATA_W'({ie_flag, ie_eol, loop_en, 2'b00});
      RA_STAT: reg_rdata = DATA_W'({active, irq, st_flag, st_eol});
      default: reg_rdata = {cur_idx, cur_remain};
    endcase
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic              halt_req,
  input  logic              loop_en,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              seg_done,
  output logic              seg_eol,
  output logic              seg_flag,
  output logic              seg_stop,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [CNT_W-1:0]  cur_remain,
  output logic              active
);
  eng_state_t        state;
  logic [ADDR_W-1:0] seg_ptr;
  logic [BYTE_W-1:0] byte_q;
  logic              d_eol, d_flag, d_halt;
  logic              halt_after;

  assign active     = (state != ST_IDLE);
  assign seg_done   = (state == ST_BYTE_RD) && (cur_remain == '0);
  assign seg_eol    = seg_done && d_eol;
  assign seg_flag   = seg_done && d_flag;
  assign seg_stop   = seg_done && d_halt;
  assign halt_after = d_halt || (d_eol && !loop_en);
  assign out_valid  = (state == ST_BYTE_OUT);
  assign out_data   = byte_q;
  assign mem_req    = (state == ST_DESC_A) || (state == ST_DESC_F) ||
                      ((state == ST_BYTE_RD) && (cur_remain != '0));

  always_comb begin
    unique case (state)
      ST_DESC_A:  mem_addr = desc_word_addr(table_base, cur_idx, 1'b0);
      ST_DESC_F:  mem_addr = desc_word_addr(table_base, cur_idx, 1'b1);
      ST_BYTE_RD: mem_addr = {seg_ptr[ADDR_W-1:2], 2'b00};
      default:    mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      seg_ptr    <= '0;
      byte_q     <= '0;
      cur_idx    <= '0;
      cur_remain <= '0;
      d_eol      <= 1'b0;
      d_flag     <= 1'b0;
      d_halt     <= 1'b0;
    end else if (halt_req) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start_go) begin
          cur_idx    <= '0;
          cur_remain <= '0;
          state      <= ST_DESC_A;
        end
        ST_DESC_A: if (mem_rvalid) begin
          seg_ptr <= mem_rdata;
          state   <= ST_DESC_F;
        end
        ST_DESC_F: if (mem_rvalid) begin
          cur_remain <= mem_rdata[CNT_W-1:0];
          d_eol      <= mem_rdata[DB_EOL];
          d_flag     <= mem_rdata[DB_FLAG];
          d_halt     <= mem_rdata[DB_HALT];
          state      <= ST_BYTE_RD;
        end
        ST_BYTE_RD: begin
          if (cur_remain == '0) begin
            if (halt_after) begin
              state <= ST_IDLE;
            end else begin
              cur_idx <= d_eol ? '0 : cur_idx + 1'b1;
              state   <= ST_DESC_A;
            end
          end else if (mem_rvalid) begin
            byte_q <= lane_byte(mem_rdata, seg_ptr[1:0]);
            state  <= ST_BYTE_OUT;
          end
        end
        ST_BYTE_OUT: if (out_ready) begin
          seg_ptr    <= seg_ptr + 1'b1;
          cur_remain <= cur_remain - 1'b1;
          state      <= ST_BYTE_RD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_chan.sv
module sgdma_chan
  import sgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              irq
);
  logic              seg_done, seg_eol, seg_flag, seg_stop;
  logic [IDX_W-1:0]  cur_idx;
  logic [CNT_W-1:0]  cur_remain;
  logic              active;
  logic [ADDR_W-1:0] table_base;
  logic              loop_en, ie_eol, ie_flag, start_go, halt_req;

  sgdma_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seg_eol(seg_eol), .seg_flag(seg_flag),
    .cur_idx(cur_idx), .cur_remain(cur_remain), .active(active),
    .table_base(table_base), .loop_en(loop_en), .ie_eol(ie_eol), .ie_flag(ie_flag),
    .start_go(start_go), .halt_req(halt_req), .irq(irq)
  );

  sgdma_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_go(start_go), .halt_req(halt_req), .loop_en(loop_en), .table_base(table_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .seg_done(seg_done), .seg_eol(seg_eol), .seg_flag(seg_flag), .seg_stop(seg_stop),
    .cur_idx(cur_idx), .cur_remain(cur_remain), .active(active)
  );
endmodule

// File: rtl/sgdma_chan_sva.sv
module sgdma_chan_sva
  import sgdma_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             active,
  input logic             mem_req,
  input logic             out_valid,
  input logic [BYTE_W-1:0] out_data,
  input logic             out_ready,
  input logic             seg_eol,
  input logic             seg_stop,
  input logic             loop_en,
  input logic             ie_eol,
  input logic             halt_req,
  input logic             irq,
  input logic [CNT_W-1:0] cur_remain
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mem_req && !out_valid)); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !halt_req) |=> (out_valid && $stable(out_data))); // R2
  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !halt_req) |=> (cur_remain == $past(cur_remain) - 1'b1)); // R4
  AST_EOL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_eol && ie_eol && !reg_we) |=> irq); // R6
  AST_EOL_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_eol && !loop_en) |=> !active); // R6
  AST_LOOP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_eol && loop_en && !seg_stop && !halt_req) |=> active); // R7
  AST_STOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    seg_stop |=> !active); // R8
  AST_HALT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !active); // R10
endmodule

bind sgdma_chan sgdma_chan_sva u_sva (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .active(active), .mem_req(mem_req),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .seg_eol(seg_eol), .seg_stop(seg_stop), .loop_en(loop_en), .ie_eol(ie_eol),
  .halt_req(halt_req), .irq(irq), .cur_remain(cur_remain)
);

// File: tb/sgdma_chan_tb.sv
module sgdma_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  int stall_mode = 0;
  int rx_n = 0;
  logic [7:0]  rx [0:63];
  logic [31:0] mem [0:255];

  sgdma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[9:2]];
    end else begin
      mem_rvalid <= 1'b0;
    end
    if (out_valid && out_ready) begin
      if (rx_n < 64) rx[rx_n] <= out_data;
      rx_n <= rx_n + 1;
    end
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    case (stall_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= (cycles % 3) != 0;
      default: out_ready <= 1'b0;
    endcase
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n = 0;
    do begin
      @(negedge clk);
      rd(2'd2, s);
      n++;
    end while (s[3] && n < 2000);
    check({req, " idle reached"}, 32'(s[3]), 32'd0);
  endtask

  task automatic fill_mem();
    for (int w = 0; w < 256; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
  endtask

  task automatic put_desc(input int i, input logic [31:0] ptr, input logic [31:0] fl);
    mem[2*i]   = ptr;
    mem[2*i+1] = fl;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R11 register reset value", v, 32'd0);
    end
    check("R11 irq after reset", 32'(irq), 32'd0);
    check("R11 no request/valid after reset", {30'd0, mem_req, out_valid}, 32'd0);
  endtask

  // R1 R2 R4 R5 R6: flag segment then end-of-list segment at an odd pointer, stalled sink
  task automatic t_basic();
    logic [31:0] v;
    fill_mem();
    put_desc(0, 32'h100, 32'h4000_0005);
    put_desc(1, 32'h203, 32'h8000_0003);
    stall_mode = 1; rx_n = 0;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h19);
    wait_idle("R6");
    check("R1 byte count", 32'(rx_n), 32'd8);
    for (int i = 0; i < 5; i++) check("R2 segment0 byte", 32'(rx[i]), 32'(pat(32'h100 + i)));
    for (int i = 0; i < 3; i++) check("R2 segment1 odd-lane byte", 32'(rx[5+i]), 32'(pat(32'h203 + i)));
    rd(2'd2, v); check("R5 R6 status eol+flag+pending", v, 32'h7);
    rd(2'd3, v); check("R4 position after end", v, 32'h0100_0000);
    wr(2'd2, 32'h2);
    rd(2'd2, v); check("R5 flag cleared, eol keeps irq", v, 32'h5);
    check("R6 irq held by eol", 32'(irq), 32'd1);
    wr(2'd2, 32'h1);
    rd(2'd2, v); check("R3 status cleared by write-one", v, 32'h0);
    check("R5 irq released", 32'(irq), 32'd0);
  endtask

  // R12: same table, enables clear
  task automatic t_no_enable();
    logic [31:0] v;
    stall_mode = 0; rx_n = 0;
    wr(2'd1, 32'h1);
    wait_idle("R12");
    rd(2'd2, v); check("R12 events recorded without pending", v, 32'h3);
    check("R12 irq low", 32'(irq), 32'd0);
    wr(2'd2, 32'h3);
  endtask

  // R8 R9: zero count flag segment, halting segment, unreached end-of-list
  task automatic t_zero_halt();
    logic [31:0] v;
    fill_mem();
    put_desc(0, 32'h140, 32'h4000_0000);
    put_desc(1, 32'h181, 32'h2000_0002);
    put_desc(2, 32'h1C0, 32'h8000_0004);
    stall_mode = 1; rx_n = 0;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h19);
    wait_idle("R8");
    check("R9 R8 only halting segment bytes", 32'(rx_n), 32'd2);
    for (int i = 0; i < 2; i++) check("R8 halting segment byte", 32'(rx[i]), 32'(pat(32'h181 + i)));
    rd(2'd2, v); check("R9 flag from empty segment, no eol", v, 32'h6);
    rd(2'd3, v); check("R8 stopped on index 1", v, 32'h0100_0000);
    wr(2'd2, 32'h3);
  endtask

  // R7 R10: looping one-segment table across a word boundary, then stop
  task automatic t_loop_stop();
    logic [31:0] v;
    int n = 0;
    int held;
    fill_mem();
    put_desc(0, 32'h1FE, 32'h8000_0003);
    stall_mode = 0; rx_n = 0;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h5);
    while (rx_n < 8 && n < 2000) begin @(negedge clk); n++; end
    for (int i = 0; i < 8; i++) check("R7 looped byte", 32'(rx[i]), 32'(pat(32'h1FE + (i % 3))));
    rd(2'd2, v); check("R7 eol set while still active", v & 32'h9, 32'h9);
    wr(2'd1, 32'h2);
    rd(2'd2, v); check("R10 stop write clears active", 32'(v[3]), 32'd0);
    held = rx_n;
    repeat (20) @(negedge clk);
    check("R10 no bytes after stop", 32'(rx_n), 32'(held));
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h3);
    rd(2'd2, v); check("R10 status back to zero", v, 32'h0);
  endtask

  // R2 R4 R10: sink fully stalled on the first byte
  task automatic t_stall();
    logic [31:0] v;
    logic [7:0]  first;
    fill_mem();
    put_desc(0, 32'h120, 32'h0000_0014);
    stall_mode = 2; rx_n = 0;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h1);
    repeat (12) @(negedge clk);
    check("R2 byte presented under stall", {31'd0, out_valid}, 32'd1);
    check("R2 first byte value", 32'(out_data), 32'(pat(32'h120)));
    first = out_data;
    rd(2'd3, v); check("R4 index 0 with full count", v, 32'h0000_0014);
    repeat (3) @(negedge clk);
    check("R2 byte held under stall", 32'(out_data), 32'(first));
    wr(2'd1, 32'h2);
    rd(2'd2, v); check("R10 halted mid-segment", 32'(v[3]), 32'd0);
    check("R10 stream valid dropped", {31'd0, out_valid}, 32'd0);
    wr(2'd2, 32'h3);
    stall_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_enable();
    t_zero_halt();
    t_loop_stop();
    t_stall();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule